// File: doc/BRIEF.md
# Message-Mode Interrupt Domain Register Bank

This block is the 32-bit register front end of an interrupt domain that delivers interrupts as messages. A host issues single-cycle requests (valid, write flag, byte offset, access size, write data); the bank answers exactly one cycle later with a response strobe, read data and an error flag. It decodes word-aligned offsets into a domain control word, an array of per-source configuration words, an array of per-source delivery targets, four bitmap arrays and four numbered registers for setting and clearing pending and enable bits, two set-pending-by-number registers (one of them byte-swapped), and a software message register.

The bank holds the pending and enable bit of every source in small per-source cells and presents them, with the domain enable, to the dispatch logic. Rectified source inputs come in from the per-source input logic and can be read back. A one-cycle scan strobe follows every accepted write, so dispatch can rescan all sources. A write to the message register emits one message descriptor on a one-cycle strobe.

Top module: `mir_regbank`

## Requirements
- R1: Only requests with size code 2 (four bytes) at offsets whose two low bits are zero are accepted; any other request returns error with read data 0 and changes no state.
- R2: Offsets outside every region return error. A bitmap array holds NWORDS = ceil((NSRC+1)/32) words, and the per-source arrays hold NSRC words, so the word after the last one is unmapped.
- R3: The domain word at offset 0x0000 reads as 0x80000004 OR (enable << 8). A write stores only bit 8, the domain enable, which drives `ie_o`.
- R4: The configuration array starts at 0x0004. The word at 0x0004 + 4*(k-1) belongs to source k and stores the low CFG_W bits of the written value; the other bits read back as 0.
- R5: The target array starts at 0x3004, with the same source mapping as R4. A write keeps bits 31:18 (hart), 17:12 (guest) and 10:0 (identity), so it is masked with 0xFFFFF7FF.
- R6: In the pending set (0x1C00) and clear (0x1D00) arrays and the enable set (0x1E00) and clear (0x1F00) arrays, bit i of word w stands for source 32*w+i. A one sets or clears that source, a zero leaves it unchanged, and bit 0 of word 0 (source 0) never holds state.
- R7: Reads return different data per array: the pending set array gives pending bits, the pending clear array gives rectified inputs, the enable set array gives enable bits, and the enable clear array gives 0.
- R8: The numbered registers (set pending 0x1CDC, clear pending 0x1DDC, set enable 0x1EDC, clear enable 0x1FDC) read as 0. A write acts on the source whose number is the write data; values 0 and above NSRC are ignored.
- R9: The set-pending-by-number registers at 0x2000 (data used as written) and 0x2004 (data byte-swapped first) read as 0.
- R10: The message register at 0x3000 stores the written value with bits 17:12 cleared. The response cycle carries one `msg_valid_o` pulse with hart = data[31:18], guest = 0 and identity = data[10:0].
- R11: A response appears exactly one cycle after each request and never otherwise. `scan_start_o` pulses with the response of every accepted write, and never for reads or errors.
- R12: `pend_o` and `en_o` bit j reflect source j+1 from the cycle the write response appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset |
| req_size | input | 2 | log2 of access bytes; 2 is the only legal value |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_err | output | 1 | Request rejected |
| rsp_rdata | output | 32 | Read data (0 on writes and errors) |
| src_rect_i | input | NSRC | Rectified source inputs, bit j = source j+1 |
| pend_o | output | NSRC | Pending bits, bit j = source j+1 |
| en_o | output | NSRC | Enable bits, bit j = source j+1 |
| ie_o | output | 1 | Domain enable |
| scan_start_o | output | 1 | Dispatch rescan strobe |
| msg_valid_o | output | 1 | Software message strobe |
| msg_hart_o | output | 14 | Message hart index |
| msg_guest_o | output | 6 | Message guest index (always 0) |
| msg_eiid_o | output | 11 | Message identity |

## Verification
A wrong source number in the decoder (an off-by-one in the configuration or target arrays, or a bitmap word sliced at the wrong base) shows up on the next read-back of that region, one cycle after the read is issued, as data in a neighbouring slot. A wrong pending or enable cell shows on `pend_o` or `en_o` in the same cycle as the write response. A masking or swap error in the domain, target, message or big-endian paths shows in the response data or the message fields of the response cycle. A bad region boundary shows as an error flag that is wrongly set or wrongly missing on the boundary word.

// File: rtl/mir_pkg.sv
package mir_pkg;

    typedef enum logic [3:0] {
        RG_NONE, RG_DOM, RG_CFG, RG_SETP, RG_SETPN, RG_CLRP, RG_CLRPN,
        RG_SETE, RG_SETEN, RG_CLRE, RG_CLREN, RG_SETPN_LE, RG_SETPN_BE,
        RG_MSG, RG_TGT
    } region_e;

    localparam logic [31:0] OFF_DOM      = 32'h0000;
    localparam logic [31:0] OFF_CFG      = 32'h0004;
    localparam logic [31:0] OFF_SETP     = 32'h1C00;
    localparam logic [31:0] OFF_SETPN    = 32'h1CDC;
    localparam logic [31:0] OFF_CLRP     = 32'h1D00;
    localparam logic [31:0] OFF_CLRPN    = 32'h1DDC;
    localparam logic [31:0] OFF_SETE     = 32'h1E00;
    localparam logic [31:0] OFF_SETEN    = 32'h1EDC;
    localparam logic [31:0] OFF_CLRE     = 32'h1F00;
    localparam logic [31:0] OFF_CLREN    = 32'h1FDC;
    localparam logic [31:0] OFF_SETPN_LE = 32'h2000;
    localparam logic [31:0] OFF_SETPN_BE = 32'h2004;
    localparam logic [31:0] OFF_MSG      = 32'h3000;
    localparam logic [31:0] OFF_TGT      = 32'h3004;

    localparam logic [31:0] DOM_FIXED    = 32'h8000_0004;
    localparam int          DOM_IE_BIT   = 8;
    localparam logic [31:0] TGT_KEEP     = 32'hFFFF_F7FF;
    localparam logic [31:0] MSG_KEEP     = 32'hFFFC_0FFF;

    function automatic logic [31:0] byte_swap(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

endpackage

// File: rtl/mir_decode.sv
module mir_decode
    import mir_pkg::*;
#(
    parameter int NSRC   = 63,
    parameter int NWORDS = 2,
    parameter int ADDR_W = 15
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output region_e           region,
    output logic [31:0]       idx
);
    localparam logic [31:0] SRC_SPAN = 32'(4 * NSRC);
    localparam logic [31:0] MAP_SPAN = 32'(4 * NWORDS);

    logic [31:0] off;

    function automatic logic in_arr(input logic [31:0] o, input logic [31:0] base,
                                    input logic [31:0] span);
        return (o >= base) && (o < base + span);
    endfunction

    always_comb begin
        off    = 32'(addr);
        region = RG_NONE;
        idx    = '0;
        if (size == 2'd2 && off[1:0] == 2'b00) begin
            if      (off == OFF_DOM)                 region = RG_DOM;
            else if (in_arr(off, OFF_CFG, SRC_SPAN)) begin region = RG_CFG;  idx = (off - OFF_CFG)  >> 2; end
            else if (in_arr(off, OFF_SETP, MAP_SPAN)) begin region = RG_SETP; idx = (off - OFF_SETP) >> 2; end
            else if (off == OFF_SETPN)               region = RG_SETPN;
            else if (in_arr(off, OFF_CLRP, MAP_SPAN)) begin region = RG_CLRP; idx = (off - OFF_CLRP) >> 2; end
            else if (off == OFF_CLRPN)               region = RG_CLRPN;
            else if (in_arr(off, OFF_SETE, MAP_SPAN)) begin region = RG_SETE; idx = (off - OFF_SETE) >> 2; end
            else if (off == OFF_SETEN)               region = RG_SETEN;
            else if (in_arr(off, OFF_CLRE, MAP_SPAN)) begin region = RG_CLRE; idx = (off - OFF_CLRE) >> 2; end
            else if (off == OFF_CLREN)               region = RG_CLREN;
            else if (off == OFF_SETPN_LE)            region = RG_SETPN_LE;
            else if (off == OFF_SETPN_BE)            region = RG_SETPN_BE;
            else if (off == OFF_MSG)                 region = RG_MSG;
            else if (in_arr(off, OFF_TGT, SRC_SPAN)) begin region = RG_TGT;  idx = (off - OFF_TGT)  >> 2; end
        end
    end

endmodule

// File: rtl/mir_srcbit.sv
module mir_srcbit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_p,
    input  logic clr_p,
    input  logic set_e,
    input  logic clr_e,
    output logic pend,
    output logic en
);
    typedef struct packed {
        logic pend;
        logic en;
    } cell_t;

    cell_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (set_p) c_d.pend = 1'b1;
        else if (clr_p) c_d.pend = 1'b0;
        if (set_e) c_d.en = 1'b1;
        else if (clr_e) c_d.en = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign pend = c_q.pend;
    assign en   = c_q.en;

endmodule

// File: rtl/mir_regbank.sv
module mir_regbank
    import mir_pkg::*;
#(
    parameter int NSRC   = 63,
    parameter int CFG_W  = 3,
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [31:0]       rsp_rdata,
    input  logic [NSRC-1:0]   src_rect_i,
    output logic [NSRC-1:0]   pend_o,
    output logic [NSRC-1:0]   en_o,
    output logic              ie_o,
    output logic              scan_start_o,
    output logic              msg_valid_o,
    output logic [13:0]       msg_hart_o,
    output logic [5:0]        msg_guest_o,
    output logic [10:0]       msg_eiid_o
);
    localparam int NWORDS = (NSRC + 1 + 31) / 32;
    localparam int NBITS  = NWORDS * 32;
    localparam int BIW    = $clog2(NBITS);
    localparam int SIW    = (NSRC > 1) ? $clog2(NSRC) : 1;

    typedef struct packed {
        logic                        ie;
        logic [NSRC-1:0][CFG_W-1:0]  cfg;
        logic [NSRC-1:0][31:0]       tgt;
        logic [31:0]                 msg_reg;
        logic                        rsp_valid;
        logic                        rsp_err;
        logic [31:0]                 rdata;
        logic                        scan;
        logic                        msg_valid;
        logic [13:0]                 msg_hart;
        logic [10:0]                 msg_eiid;
    } bank_t;

    bank_t s_d, s_q;

    region_e           region;
    logic [31:0]       idx;
    logic [SIW-1:0]    sidx;
    logic [BIW-1:0]    wbase;
    logic [NBITS-1:0]  set_p_v, clr_p_v, set_e_v, clr_e_v;
    logic [NBITS-1:0]  pend_v, en_v, rect_v;
    logic [31:0]       num;
    logic              num_ok;

    mir_decode #(.NSRC(NSRC), .NWORDS(NWORDS), .ADDR_W(ADDR_W)) u_dec (
        .addr   (req_addr),
        .size   (req_size),
        .region (region),
        .idx    (idx)
    );

    generate
        for (genvar g = 0; g < NSRC; g++) begin : g_src
            mir_srcbit u_bit (
                .clk   (clk),
                .rst_n (rst_n),
                .set_p (set_p_v[g+1]),
                .clr_p (clr_p_v[g+1]),
                .set_e (set_e_v[g+1]),
                .clr_e (clr_e_v[g+1]),
                .pend  (pend_o[g]),
                .en    (en_o[g])
            );
        end
    endgenerate

    assign pend_v = NBITS'({pend_o, 1'b0});
    assign en_v   = NBITS'({en_o, 1'b0});
    assign rect_v = NBITS'({src_rect_i, 1'b0});
    assign sidx   = SIW'(idx);
    assign wbase  = BIW'({idx, 5'b0});

    always_comb begin
        case (region)
            RG_SETPN_BE: num = byte_swap(req_wdata);
            default:     num = req_wdata;
        endcase
        num_ok = (num != 32'd0) && (num <= 32'(NSRC));
    end

    always_comb begin
        s_d           = s_q;
        s_d.rsp_valid = req_valid;
        s_d.rsp_err   = 1'b0;
        s_d.rdata     = '0;
        s_d.scan      = 1'b0;
        s_d.msg_valid = 1'b0;
        set_p_v = '0;
        clr_p_v = '0;
        set_e_v = '0;
        clr_e_v = '0;
        if (req_valid) begin
            if (region == RG_NONE) begin
                s_d.rsp_err = 1'b1;
            end else if (req_write) begin
                s_d.scan = 1'b1;
                case (region)
                    RG_DOM:  s_d.ie = req_wdata[DOM_IE_BIT];
                    RG_CFG:  s_d.cfg[sidx] = req_wdata[CFG_W-1:0];
                    RG_TGT:  s_d.tgt[sidx] = req_wdata & TGT_KEEP;
                    RG_SETP: set_p_v[wbase +: 32] = req_wdata;
                    RG_CLRP: clr_p_v[wbase +: 32] = req_wdata;
                    RG_SETE: set_e_v[wbase +: 32] = req_wdata;
                    RG_CLRE: clr_e_v[wbase +: 32] = req_wdata;
                    RG_SETPN, RG_SETPN_LE, RG_SETPN_BE:
                        if (num_ok) set_p_v[BIW'(num)] = 1'b1;
                    RG_CLRPN: if (num_ok) clr_p_v[BIW'(num)] = 1'b1;
                    RG_SETEN: if (num_ok) set_e_v[BIW'(num)] = 1'b1;
                    RG_CLREN: if (num_ok) clr_e_v[BIW'(num)] = 1'b1;
                    RG_MSG: begin
                        s_d.msg_reg   = req_wdata & MSG_KEEP;
                        s_d.msg_valid = 1'b1;
                        s_d.msg_hart  = req_wdata[31:18];
                        s_d.msg_eiid  = req_wdata[10:0];
                    end
                    default: ;
                endcase
            end else begin
                case (region)
                    RG_DOM:  s_d.rdata = DOM_FIXED | (32'(s_q.ie) << DOM_IE_BIT);
                    RG_CFG:  s_d.rdata = 32'(s_q.cfg[sidx]);
                    RG_TGT:  s_d.rdata = s_q.tgt[sidx];
                    RG_SETP: s_d.rdata = pend_v[wbase +: 32];
                    RG_CLRP: s_d.rdata = rect_v[wbase +: 32];
                    RG_SETE: s_d.rdata = en_v[wbase +: 32];
                    RG_MSG:  s_d.rdata = s_q.msg_reg;
                    default: s_d.rdata = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rsp_valid    = s_q.rsp_valid;
    assign rsp_err      = s_q.rsp_err;
    assign rsp_rdata    = s_q.rdata;
    assign ie_o         = s_q.ie;
    assign scan_start_o = s_q.scan;
    assign msg_valid_o  = s_q.msg_valid;
    assign msg_hart_o   = s_q.msg_hart;
    assign msg_guest_o  = 6'd0;
    assign msg_eiid_o   = s_q.msg_eiid;

endmodule

// File: rtl/mir_regbank_chk.sv
module mir_regbank_chk #(
    parameter int NSRC = 63
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            rsp_valid,
    input logic            rsp_err,
    input logic            scan_start_o,
    input logic            msg_valid_o,
    input logic [5:0]      msg_guest_o,
    input logic [NSRC-1:0] pend_o,
    input logic [NSRC-1:0] en_o,
    input logic            ie_o
);
    assert_rsp_follows_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_no_spurious_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_scan_on_good_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
        scan_start_o |-> (rsp_valid && !rsp_err));

    assert_err_no_change_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> ($stable(pend_o) && $stable(en_o) && $stable(ie_o)));

    assert_ie_only_by_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_start_o |-> $stable(ie_o));

    assert_msg_guest_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid_o |-> (msg_guest_o == 6'd0 && scan_start_o));

    assert_bits_only_by_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_start_o |-> ($stable(pend_o) && $stable(en_o)));
endmodule

bind mir_regbank mir_regbank_chk #(.NSRC(NSRC)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .rsp_valid    (rsp_valid),
    .rsp_err      (rsp_err),
    .scan_start_o (scan_start_o),
    .msg_valid_o  (msg_valid_o),
    .msg_guest_o  (msg_guest_o),
    .pend_o       (pend_o),
    .en_o         (en_o),
    .ie_o         (ie_o)
);

// File: tb/mir_regbank_tb.sv
`timescale 1ns/1ps
module mir_regbank_tb;
    localparam int NSRC = 63;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [14:0]       req_addr = '0;
    logic [1:0]        req_size = 2'd2;
    logic [31:0]       req_wdata = '0;
    logic              rsp_valid, rsp_err;
    logic [31:0]       rsp_rdata;
    logic [NSRC-1:0]   src_rect_i = '0;
    logic [NSRC-1:0]   pend_o, en_o;
    logic              ie_o, scan_start_o, msg_valid_o;
    logic [13:0]       msg_hart_o;
    logic [5:0]        msg_guest_o;
    logic [10:0]       msg_eiid_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] rd;
    logic        er, sc;

    always #2.5 clk = ~clk;

    mir_regbank u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .src_rect_i(src_rect_i), .pend_o(pend_o), .en_o(en_o), .ie_o(ie_o),
        .scan_start_o(scan_start_o), .msg_valid_o(msg_valid_o),
        .msg_hart_o(msg_hart_o), .msg_guest_o(msg_guest_o), .msg_eiid_o(msg_eiid_o)
    );

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // one request; response sampled at the falling edge after the capturing edge
    task automatic access(input logic wr, input logic [14:0] a, input logic [31:0] d,
                          input logic [1:0] sz);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_size = sz;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_size = 2'd2;
        check("R11 response strobe", 64'(rsp_valid), 64'd1);
        rd = rsp_rdata; er = rsp_err; sc = scan_start_o;
    endtask

    task automatic wr(input logic [14:0] a, input logic [31:0] d);
        access(1'b1, a, d, 2'd2);
    endtask

    task automatic rd_chk(input string tag, input logic [14:0] a, input logic [31:0] exp);
        access(1'b0, a, 32'd0, 2'd2);
        check(tag, 64'(rd), 64'(exp));
        check({tag, " no error"}, 64'(er), 64'd0);
    endtask

    task automatic t_reset();
        check("R11 idle after reset", 64'(rsp_valid), 64'd0);
        check("R12 pend reset", 64'(pend_o), 64'd0);
        check("R12 en reset", 64'(en_o), 64'd0);
        rd_chk("R3 domain reset read", 15'h0000, 32'h8000_0004);
    endtask

    task automatic t_domain();
        wr(15'h0000, 32'hFFFF_FFFF);
        check("R11 scan after write", 64'(sc), 64'd1);
        check("R3 ie set", 64'(ie_o), 64'd1);
        rd_chk("R3 domain read ie", 15'h0000, 32'h8000_0104);
        check("R11 no scan on read", 64'(sc), 64'd0);
        wr(15'h0000, 32'hFFFF_FEFF);
        rd_chk("R3 domain ie cleared", 15'h0000, 32'h8000_0004);
    endtask

    task automatic t_cfg();
        wr(15'h0004, 32'hFFFF_FFFF);
        wr(15'h0004 + 15'(4 * (NSRC - 1)), 32'h0000_0005);
        rd_chk("R4 cfg source 1 masked", 15'h0004, 32'h7);
        rd_chk("R4 cfg source 2 untouched", 15'h0008, 32'h0);
        rd_chk("R4 cfg last source", 15'h0004 + 15'(4 * (NSRC - 1)), 32'h5);
    endtask

    task automatic t_target();
        wr(15'h3004, 32'hFFFF_FFFF);
        rd_chk("R5 target masked", 15'h3004, 32'hFFFF_F7FF);
        wr(15'h3008, 32'h1234_5ABC);
        rd_chk("R5 target source 2", 15'h3008, 32'h1234_52BC);
    endtask

    task automatic t_pend_map();
        wr(15'h1C00, 32'hFFFF_FFFF);
        rd_chk("R6 source 0 bit ignored", 15'h1C00, 32'hFFFF_FFFE);
        wr(15'h1D00, 32'h0000_000F);
        rd_chk("R6 clear ones only", 15'h1C00, 32'hFFFF_FFF0);
        wr(15'h1C04, 32'hFFFF_FFFF);
        check("R12 pend vector", 64'(pend_o), 64'({32'hFFFF_FFFF, 31'h7FFF_FFF8}));
        wr(15'h1D00, 32'hFFFF_FFFF);
        wr(15'h1D04, 32'hFFFF_FFFF);
        check("R6 all cleared", 64'(pend_o), 64'd0);
    endtask

    task automatic t_rect();
        logic [NSRC-1:0] pat;
        pat = {32'h1234_5678, 31'h0ACE_1234};
        src_rect_i = pat;
        rd_chk("R7 clear-pending word 0 gives inputs", 15'h1D00, {pat[30:0], 1'b0});
        rd_chk("R7 clear-pending word 1 gives inputs", 15'h1D04, pat[62:31]);
        rd_chk("R7 set-pending still pending", 15'h1C00, 32'h0);
        src_rect_i = '0;
    endtask

    task automatic t_enable();
        wr(15'h1E00, 32'h0000_0006);
        rd_chk("R7 set-enable reads enables", 15'h1E00, 32'h6);
        rd_chk("R7 clear-enable reads zero", 15'h1F00, 32'h0);
        wr(15'h1F00, 32'h0000_0002);
        rd_chk("R6 enable cleared", 15'h1E00, 32'h4);
        check("R12 en vector", 64'(en_o), 64'h2);
    endtask

    task automatic t_numbered();
        wr(15'h1EDC, 32'd40);
        rd_chk("R8 set-enable by number", 15'h1E04, 32'h100);
        rd_chk("R8 numbered reads zero", 15'h1EDC, 32'h0);
        wr(15'h1FDC, 32'd40);
        rd_chk("R8 clear-enable by number", 15'h1E04, 32'h0);
        wr(15'h1EDC, 32'd0);
        wr(15'h1EDC, 32'd64);
        rd_chk("R8 out of range word 0", 15'h1E00, 32'h4);
        rd_chk("R8 out of range word 1", 15'h1E04, 32'h0);
        wr(15'h1CDC, 32'd5);
        rd_chk("R8 set-pending by number", 15'h1C00, 32'h20);
        wr(15'h1DDC, 32'd5);
        rd_chk("R8 clear-pending by number", 15'h1C00, 32'h0);
        rd_chk("R8 clear-pending number reads zero", 15'h1DDC, 32'h0);
    endtask

    task automatic t_endian();
        wr(15'h2000, 32'd7);
        rd_chk("R9 little-endian number", 15'h1C00, 32'h80);
        wr(15'h2004, 32'h0900_0000);
        rd_chk("R9 big-endian swapped", 15'h1C00, 32'h280);
        wr(15'h2004, 32'h0000_0009);
        rd_chk("R9 big-endian swap out of range", 15'h1C00, 32'h280);
        rd_chk("R9 LE reads zero", 15'h2000, 32'h0);
        rd_chk("R9 BE reads zero", 15'h2004, 32'h0);
    endtask

    task automatic t_msg();
        wr(15'h3000, 32'hABCD_F123);
        check("R10 msg strobe", 64'(msg_valid_o), 64'd1);
        check("R10 msg hart", 64'(msg_hart_o), 64'h2AF3);
        check("R10 msg guest", 64'(msg_guest_o), 64'd0);
        check("R10 msg identity", 64'(msg_eiid_o), 64'h123);
        @(negedge clk);
        check("R10 single pulse", 64'(msg_valid_o), 64'd0);
        rd_chk("R10 stored guest cleared", 15'h3000, 32'hABCC_0123);
    endtask

    task automatic t_errors();
        access(1'b0, 15'h0000, 32'd0, 2'd0);
        check("R1 short size error", 64'(er), 64'd1);
        access(1'b0, 15'h3002, 32'd0, 2'd2);
        check("R1 misaligned error", 64'(er), 64'd1);
        access(1'b1, 15'h1E00, 32'hFFFF_FFFF, 2'd1);
        check("R1 rejected write error", 64'(er), 64'd1);
        check("R11 no scan on error", 64'(sc), 64'd0);
        rd_chk("R1 rejected write no effect", 15'h1E00, 32'h4);
        access(1'b0, 15'h1C00 + 15'(4 * ((NSRC + 32) / 32)), 32'd0, 2'd2);
        check("R2 bitmap past last word", 64'(er), 64'd1);
        access(1'b0, 15'h0004 + 15'(4 * NSRC), 32'd0, 2'd2);
        check("R2 cfg past last source", 64'(er), 64'd1);
        access(1'b0, 15'h3004 + 15'(4 * NSRC), 32'd0, 2'd2);
        check("R2 target past last source", 64'(er), 64'd1);
        access(1'b0, 15'h0FFC, 32'd0, 2'd2);
        check("R2 gap error", 64'(er), 64'd1);
        check("R1 error data zero", 64'(rd), 64'd0);
    endtask

    initial begin : watchdog
        #(5.0 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_domain();
        t_cfg();
        t_target();
        t_pend_map();
        t_rect();
        t_enable();
        t_numbered();
        t_endian();
        t_msg();
        t_errors();
        repeat (2) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule